// File: doc/BRIEF.md
# Differential Clock Fan-out Gate and Power-Down Controller

This block is the digital control that sits between a clock source and a bank of differential clock output pairs plus one single-ended reference output. It does not generate or modulate the clock. It decides, pair by pair, whether the clock reaches an output. It also keeps every output quiet during power-down and before the phase-locked loop reports lock.

A combined power-good/power-down input does two jobs. Its first low-to-high transition after reset captures the board straps: a three-level spread strap, already decoded into two bits, and a one-bit address strap. These give a 2-bit spread mode and a 7-bit serial-bus device address, and later transitions never capture them again. After that, a low level on the input means power-down and a high level means normal running. A pair runs only when four things hold: power is good, its register enable bit is set, its active-low enable pin is low, and the lock flag is high. The pins, the lock flag and the power-good input cross into the control clock through two-flop synchronizers. The source clock is given as a level sampled in the control clock domain. A pair's run state changes only while that level is low, so the true leg never produces a shortened pulse.

Top module: `ckout_gate_ctrl`

## Requirements
- R1: After a synchronous reset, all `dif_t` and `dif_c` bits are 0, `ref_drv` is 0, `ss_mode` is 2'b00 and `bus_addr` is 7'b1101000.
- R2: On the first power-good rise after reset, the spread straps are captured: `strap_ss_hi`=1 gives `ss_mode`=2'b10 (-0.5%), `strap_ss_hi`=0 with `strap_ss_mid`=1 gives 2'b01 (-0.25%), and both 0 give 2'b00 (off). The new value appears on the third rising clock edge after the input changes.
- R3: On that same first rise, `strap_addr`=0 captures `bus_addr`=7'b1101000 and `strap_addr`=1 captures 7'b1101010.
- R4: Later power-good rises do not capture the straps again. Strap changes after the first capture have no effect on `ss_mode` or `bus_addr`.
- R5: `ref_drv` (1 = reference driven, 0 = high impedance) stays 0 until the first power-good rise and stays 1 after it until reset. While power-good is low, `ref_out` is 0. While it is high, `ref_out` follows `src_lvl` with a one-cycle delay.
- R6: While power-good is low, both legs of every pair are 0.
- R7: A pair whose `oe_n` bit is 1 holds both legs at 0.
- R8: A pair whose `reg_en` bit is 0 holds both legs at 0.
- R9: While `pll_lock` is 0, no pair toggles and both legs stay 0.
- R10: A running pair drives `dif_t` equal to the previous cycle's `src_lvl` and `dif_c` equal to its inverse. The two legs are never both 1.
- R11: A pair's run state changes only on an edge where `src_lvl` is 0. Enabling while the source is held high leaves the pair at 0. Disabling while the source is held high leaves `dif_t` at 1 until the source goes low.
- R12: `oe_n`, `pll_lock` and `pwrgd` pass through two synchronizing flops. With the source low on every edge, a pin change reaches a pair's run state on the third edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd | input | 1 | Power-good (high) / power-down (low), asynchronous |
| strap_ss_hi | input | 1 | Spread strap sensed at high level |
| strap_ss_mid | input | 1 | Spread strap sensed at mid level |
| strap_addr | input | 1 | Address strap |
| oe_n | input | NPAIR | Active-low per-pair enable pins, asynchronous |
| reg_en | input | NPAIR | Per-pair register enable bits |
| pll_lock | input | 1 | PLL lock flag, asynchronous |
| src_lvl | input | 1 | Source clock level sampled in the control domain |
| dif_t | output | NPAIR | True legs of the output pairs |
| dif_c | output | NPAIR | Complement legs of the output pairs |
| ref_out | output | 1 | Reference output level |
| ref_drv | output | 1 | Reference driver enable (0 = high impedance) |
| ss_mode | output | 2 | Captured spread mode |
| bus_addr | output | 7 | Captured serial-bus address |

## Verification
The bench resets the block for every spread/address strap combination. It checks the exact edge at which capture happens, then changes the straps and cycles power-good again. A design that recaptured the straps, or that let the address strap default wrongly, would then show a different mode or address. It sweeps all 256 enable-pin patterns against a derived register pattern and checks each cycle against the lagged source. It also holds the source high across enable and disable changes: a design that gated on any edge would start with a partial high or cut a high phase short. Separate windows with lock low and with power-good low check the quiet states, the sticky reference enable, and the synchronizer latency counted edge by edge.

// File: rtl/ckout_pkg.sv
package ckout_pkg;
  typedef enum logic [1:0] {
    SS_OFF     = 2'b00,
    SS_QUARTER = 2'b01,
    SS_HALF    = 2'b10
  } ss_mode_e;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_BASE = 7'b1101000;
  localparam logic [ADDR_W-1:0] ADDR_STEP = 7'b0000010;
endpackage

// File: rtl/ckout_sync2.sv
module ckout_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ckout_strap_latch.sv
module ckout_strap_latch
  import ckout_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_s,
  input  logic              ss_hi,
  input  logic              ss_mid,
  input  logic              addr_sel,
  output logic              seen,
  output ss_mode_e          ss_mode,
  output logic [ADDR_W-1:0] bus_addr
);
  ss_mode_e strap_dec;

  always_comb begin
    if (ss_hi)       strap_dec = SS_HALF;
    else if (ss_mid) strap_dec = SS_QUARTER;
    else             strap_dec = SS_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      ss_mode  <= SS_OFF;
      bus_addr <= ADDR_BASE;
    end else if (pwr_s && !seen) begin
      seen     <= 1'b1;
      ss_mode  <= strap_dec;
      bus_addr <= addr_sel ? (ADDR_BASE | ADDR_STEP) : ADDR_BASE;
    end
  end

  // R5: once captured, the reference enable never drops before reset
  p_seen_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    $past(seen) |-> seen);
  // R4: no recapture after the first rise
  p_straps_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(seen)) |-> ($stable(ss_mode) && $stable(bus_addr)));
endmodule

// File: rtl/ckout_pair_gate.sv
module ckout_pair_gate (
  input  logic clk,
  input  logic rst,
  input  logic src_lvl,
  input  logic want,
  output logic dif_t,
  output logic dif_c
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      dif_t <= 1'b0;
      dif_c <= 1'b0;
    end else begin
      if (!src_lvl) run_q <= want;
      dif_t <= run_q & src_lvl;
      dif_c <= run_q & ~src_lvl;
    end
  end

  // R10: legs never both high
  p_legs_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(dif_t && dif_c));
  // R11: the true leg only falls after the source went low
  p_no_runt_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(dif_t) |-> !$past(src_lvl));
  // R10: the true leg only rises after the source was high
  p_rise_src_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(dif_t) |-> $past(src_lvl));
endmodule

// File: rtl/ckout_gate_ctrl.sv
module ckout_gate_ctrl
  import ckout_pkg::*;
#(
  parameter int NPAIR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrgd,
  input  logic              strap_ss_hi,
  input  logic              strap_ss_mid,
  input  logic              strap_addr,
  input  logic [NPAIR-1:0]  oe_n,
  input  logic [NPAIR-1:0]  reg_en,
  input  logic              pll_lock,
  input  logic              src_lvl,
  output logic [NPAIR-1:0]  dif_t,
  output logic [NPAIR-1:0]  dif_c,
  output logic              ref_out,
  output logic              ref_drv,
  output logic [1:0]        ss_mode,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam logic [NPAIR-1:0] OE_IDLE = '1;

  logic [NPAIR-1:0] oe_s;
  logic [1:0]       ctl_s;
  logic             pwr_s;
  logic             lock_s;
  ss_mode_e         mode_q;

  // R12: two-flop synchronizers for the asynchronous inputs
  ckout_sync2 #(.W(NPAIR), .RST_VAL(OE_IDLE)) u_sync_oe (
    .clk(clk), .rst(rst), .d(oe_n), .q(oe_s)
  );
  ckout_sync2 #(.W(2), .RST_VAL(2'b00)) u_sync_ctl (
    .clk(clk), .rst(rst), .d({pll_lock, pwrgd}), .q(ctl_s)
  );
  assign pwr_s  = ctl_s[0];
  assign lock_s = ctl_s[1];

  ckout_strap_latch u_strap (
    .clk(clk), .rst(rst), .pwr_s(pwr_s),
    .ss_hi(strap_ss_hi), .ss_mid(strap_ss_mid), .addr_sel(strap_addr),
    .seen(ref_drv), .ss_mode(mode_q), .bus_addr(bus_addr)
  );
  assign ss_mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) ref_out <= 1'b0;
    else     ref_out <= pwr_s & src_lvl;
  end

  // R5: an undriven reference carries no level
  p_ref_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !ref_drv |-> !ref_out);

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic want;
    assign want = pwr_s & lock_s & reg_en[g] & ~oe_s[g];
    ckout_pair_gate u_gate (
      .clk(clk), .rst(rst), .src_lvl(src_lvl), .want(want),
      .dif_t(dif_t[g]), .dif_c(dif_c[g])
    );
  end
endmodule

// File: tb/ckout_gate_ctrl_test.sv
module ckout_gate_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrgd = 1'b0, strap_ss_hi = 1'b0, strap_ss_mid = 1'b0, strap_addr = 1'b0;
  logic [NP-1:0] oe_n = '1, reg_en = '1;
  logic pll_lock = 1'b0, src_lvl = 1'b0;
  logic [NP-1:0] dif_t, dif_c;
  logic ref_out, ref_drv;
  logic [1:0] ss_mode;
  logic [6:0] bus_addr;
  int total = 0, bad = 0;
  logic src_prev = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ckout_gate_ctrl #(.NPAIR(NP)) uut (
    .clk(clk), .rst(rst), .pwrgd(pwrgd), .strap_ss_hi(strap_ss_hi),
    .strap_ss_mid(strap_ss_mid), .strap_addr(strap_addr), .oe_n(oe_n),
    .reg_en(reg_en), .pll_lock(pll_lock), .src_lvl(src_lvl), .dif_t(dif_t),
    .dif_c(dif_c), .ref_out(ref_out), .ref_drv(ref_drv), .ss_mode(ss_mode),
    .bus_addr(bus_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drive the source on the falling edge, remembering what the next rise samples
  task automatic tick_src(input logic v);
    src_lvl = v;
    src_prev = v;
    step();
  endtask

  task automatic do_reset();
    rst = 1'b1; pwrgd = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  // toggle the source, settle, then compare every pair with the computed gate
  task automatic window(input string req, input logic pg, input logic lk);
    logic [NP-1:0] en, bad_t;
    logic ref_bad;
    en = (pg && lk) ? (reg_en & ~oe_n) : '0;
    bad_t = '0; ref_bad = 1'b0;
    repeat (7) tick_src(~src_lvl);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < NP; p++) begin
        if (dif_t[p] !== (en[p] & src_prev) || dif_c[p] !== (en[p] & ~src_prev))
          bad_t[p] = 1'b1;
      end
      if (ref_out !== (pg & src_prev)) ref_bad = 1'b1;
      tick_src(~src_lvl);
    end
    chk(bad_t == '0, req, bad_t, 0);
    chk(!ref_bad, "R5 ref level", ref_bad, 0);
  endtask

  initial begin
    int ss, ad;
    logic [1:0] exp_mode;
    logic [6:0] exp_addr;
    for (int c = 0; c < 6; c++) begin
      ss = c % 3; ad = c / 3;
      do_reset();
      // R1 reset state
      chk(dif_t == '0 && dif_c == '0, "R1 pairs low", dif_t, 0);
      chk(!ref_drv && ss_mode == 2'b00 && bus_addr == 7'b1101000, "R1 strap outputs",
          {ref_drv, ss_mode, bus_addr}, {1'b0, 2'b00, 7'b1101000});
      strap_ss_hi = (ss == 2); strap_ss_mid = (ss == 1); strap_addr = ad[0];
      repeat (3) step();
      chk(!ref_drv, "R5 hi-z before first rise", ref_drv, 0);
      pwrgd = 1'b1;
      repeat (2) step();
      chk(!ref_drv && ss_mode == 2'b00, "R2 not captured before third edge",
          {ref_drv, ss_mode}, 0);
      step();
      exp_mode = (ss == 2) ? 2'b10 : (ss == 1) ? 2'b01 : 2'b00;
      exp_addr = ad[0] ? 7'b1101010 : 7'b1101000;
      chk(ref_drv == 1'b1, "R5 driven after first rise", ref_drv, 1);
      chk(ss_mode == exp_mode, "R2 spread capture", ss_mode, exp_mode);
      chk(bus_addr == exp_addr, "R3 address capture", bus_addr, exp_addr);
      strap_ss_hi = ((ss + 1) % 3 == 2); strap_ss_mid = ((ss + 1) % 3 == 1);
      strap_addr = ~ad[0];
      pwrgd = 1'b0;
      repeat (4) step();
      chk(ref_drv && !ref_out, "R5 low in power-down", {ref_drv, ref_out}, 2'b10);
      pwrgd = 1'b1;
      repeat (4) step();
      chk(ss_mode == exp_mode && bus_addr == exp_addr, "R4 no recapture",
          {ss_mode, bus_addr}, {exp_mode, exp_addr});
    end

    // R7 R8 R10: sweep of all pin patterns with a derived register pattern
    pll_lock = 1'b1;
    for (int v = 0; v < 256; v++) begin
      oe_n = v[7:0];
      reg_en = {oe_n[3:0], oe_n[7:4]} ^ 8'h5A;
      window("R7 R8 R10 pin and register gating", 1'b1, 1'b1);
    end
    oe_n = '0; reg_en = '1;
    pll_lock = 1'b0;
    window("R9 quiet without lock", 1'b1, 1'b0);
    pll_lock = 1'b1;
    window("R10 all running", 1'b1, 1'b1);
    pwrgd = 1'b0;
    window("R6 power-down quiet", 1'b0, 1'b1);
    pwrgd = 1'b1;
    window("R6 power-down exit", 1'b1, 1'b1);

    // R11: enable and disable with the source held high
    oe_n = '1;
    repeat (6) tick_src(1'b0);
    oe_n = '0;
    repeat (6) tick_src(1'b1);
    chk(dif_t == '0, "R11 enable waits for low source", dif_t, 0);
    tick_src(1'b0);
    tick_src(1'b1);
    chk(dif_t == '1, "R11 enable after low source", dif_t, 8'hFF);
    oe_n = '1;
    repeat (6) tick_src(1'b1);
    chk(dif_t == '1, "R11 high phase not cut", dif_t, 8'hFF);
    tick_src(1'b0);
    repeat (2) tick_src(1'b1);
    chk(dif_t == '0, "R11 disable after low source", dif_t, 0);

    // R12: pin change reaches the run state on the third edge
    repeat (4) tick_src(1'b0);
    oe_n = '0;
    repeat (2) tick_src(1'b0);
    tick_src(1'b1);
    chk(dif_t == '0, "R12 not before third edge", dif_t, 0);
    tick_src(1'b0);
    tick_src(1'b1);
    chk(dif_t == '1, "R12 enabled after sync", dif_t, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule